// File: doc/BRIEF.md
# Shared-Memory Multicycle Processor Datapath

This block is the data side of a 32-bit processor that runs each instruction over several clock cycles. One memory holds both program and data. One ALU computes the next program counter, the branch target, effective addresses and every arithmetic result. Between steps, values sit in dedicated registers: the program counter, the instruction register, the memory data register, two operand latches and a result latch. A 32-entry register file completes the datapath, and its entry 0 always reads as zero.

There is no sequencer inside the block. Every multiplexer select and every write enable is a port, and an external controller (or a bench) steps the datapath one register transfer per cycle. The supported instruction classes are register-register arithmetic, OR with an immediate, word load, word store and branch on equal. Program and data words are placed in the memory through a dedicated word-wide load port. Memory reads complete in the same cycle.

Top module: `mc_shared_datapath`

## Requirements
- R1: When `rst_n` is low at a rising edge, `pc_q`, `ir_q`, `mdr_q`, `a_q`, `b_q` and `res_q` become 0, and all 32 register-file entries become 0.
- R2: The memory is addressed by `pc_q` when `addr_sel`=0 and by `res_q` when `addr_sel`=1. The word index is byte address bits [MEM_AW+1:2]. With `mem_rd`=1, `mdr_q` captures the addressed word.
- R3: The first ALU operand is `pc_q` when `opa_sel`=0 and `a_q` when it is 1. The second operand, chosen by `opb_sel`, is 4 for 0, `b_q` for 1, the extended immediate shifted left by 2 for 2, and the extended immediate for 3.
- R4: For `alu_mode`, 0 adds, 1 subtracts (first minus second), 2 follows the function field and 3 is a bitwise OR. `alu_zero` is 1 exactly when the ALU result is zero.
- R5: In function-field mode, funct 0x21 adds, 0x23 subtracts, 0x24 is AND, 0x25 is OR, and 0x2A gives 1 when the first operand is less than the second as signed numbers and 0 otherwise. Every other funct value adds.
- R6: The immediate is `ir_q`[15:0]. It is zero-extended when `imm_sext`=0 and sign-extended when `imm_sext`=1.
- R7: With `rf_wr`=1, the register file writes entry rd (`ir_q`[15:11]) when `dst_sel`=1, or entry rt (`ir_q`[20:16]) when `dst_sel`=0. The data written is `res_q` when `wb_sel`=0 and `mdr_q` when `wb_sel`=1. A write to entry 0 leaves it reading 0.
- R8: `pc_q` is loaded when `pc_wr`=1, or when `pc_wr_cond`=1 and `alu_zero`=1. The value loaded is the live ALU result when `pc_src`=0 and `res_q` when `pc_src`=1. Otherwise `pc_q` holds.
- R9: `ir_q` loads the addressed memory word only when `ir_wr`=1. `a_q` and `b_q` load register file entries rs (`ir_q`[25:21]) and rt only when `a_wr` and `b_wr` are 1. `res_q` loads the ALU result only when `res_wr`=1.
- R10: With `mem_wr`=1, `b_q` is stored at the addressed word. With `ld_en`=1, `ld_data` is stored at word `ld_addr`, and this takes priority over `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load-port write strobe |
| ld_addr | input | MEM_AW | Load-port word index |
| ld_data | input | 32 | Load-port data |
| pc_wr | input | 1 | Unconditional program-counter write |
| pc_wr_cond | input | 1 | Program-counter write when the ALU result is zero |
| pc_src | input | 1 | Program-counter source: 0 live ALU, 1 result latch |
| ir_wr | input | 1 | Instruction register enable |
| mem_rd | input | 1 | Memory data register enable |
| mem_wr | input | 1 | Store operand B to memory |
| addr_sel | input | 1 | Memory address: 0 program counter, 1 result latch |
| a_wr | input | 1 | Operand A enable |
| b_wr | input | 1 | Operand B enable |
| res_wr | input | 1 | Result latch enable |
| opa_sel | input | 1 | First ALU operand select |
| opb_sel | input | 2 | Second ALU operand select |
| alu_mode | input | 2 | ALU operation select |
| imm_sext | input | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| dst_sel | input | 1 | Write register: 0 rt, 1 rd |
| wb_sel | input | 1 | Write data: 0 result latch, 1 memory data |
| rf_wr | input | 1 | Register file write enable |
| pc_q | output | 32 | Program counter |
| ir_q | output | 32 | Instruction register |
| mdr_q | output | 32 | Memory data register |
| a_q | output | 32 | Operand A latch |
| b_q | output | 32 | Operand B latch |
| res_q | output | 32 | ALU result latch |
| alu_zero | output | 1 | ALU result equals zero |

## Verification
The bench drives several hundred complete instructions. It sweeps every function code, including undefined ones, across a set of corner operands: zero, all ones, and the largest and smallest signed values. If the set-less-than were unsigned, or if undefined codes did not fall back to add, the result latch would read wrong. OR-immediates with bit 15 set catch an extension that sign-extends where it should zero-extend. Loads and stores with negative offsets catch the opposite mistake. Branches are run both taken and not taken, with forward and backward offsets, to expose a conditional write that ignores the zero flag or takes the wrong source. Writes aimed at entry 0 are followed by reads of entry 0, which would return the written value if that entry were writable.

// File: rtl/mc_dp_pkg.sv
// Package: shared types and encodings for the multicycle datapath.
// Assumes a 32-bit word and the instruction field layout given in the brief.
package mc_dp_pkg;

    localparam int XLEN = 32;

    typedef logic [XLEN-1:0] word_t;

    // Main ALU operation select.
    typedef enum logic [1:0] {
        ALU_ADD   = 2'd0,
        ALU_SUB   = 2'd1,
        ALU_FUNCT = 2'd2,
        ALU_OR    = 2'd3
    } alu_mode_e;

    // Second-operand select.
    typedef enum logic [1:0] {
        OPB_FOUR   = 2'd0,
        OPB_REG    = 2'd1,
        OPB_IMM_SH = 2'd2,
        OPB_IMM    = 2'd3
    } opb_sel_e;

    // Function-field codes understood by the ALU.
    localparam logic [5:0] FN_ADD = 6'h21;
    localparam logic [5:0] FN_SUB = 6'h23;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    // Field extraction helpers.
    function automatic logic [4:0] fld_rs(input word_t w);
        return w[25:21];
    endfunction

    function automatic logic [4:0] fld_rt(input word_t w);
        return w[20:16];
    endfunction

    function automatic logic [4:0] fld_rd(input word_t w);
        return w[15:11];
    endfunction

    function automatic logic [5:0] fld_fn(input word_t w);
        return w[5:0];
    endfunction

    function automatic logic [15:0] fld_imm(input word_t w);
        return w[15:0];
    endfunction

endpackage

// File: rtl/mc_regfile.sv
// Module: mc_regfile
// Register file with two combinational read ports and one synchronous write
// port. Entry 0 is never written, so it keeps its reset value of zero.
// Assumes a synchronous active-low reset that clears every entry.
module mc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ra,
    input  logic [IW-1:0] rb,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rda,
    output logic [W-1:0]  rdb
);

    logic [W-1:0] regs_q [NREG];

    // Purpose: clear on reset, otherwise write any entry other than zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    // Purpose: combinational read of both ports.
    always_comb begin
        rda = regs_q[ra];
        rdb = regs_q[rb];
    end

    // R7
    r0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra == '0) |-> (rda == '0));

endmodule

// File: rtl/mc_alu.sv
// Module: mc_alu
// Single shared ALU. The mode selects add, subtract, OR or a function-field
// decode. Undefined function codes fall back to add. Purely combinational.
module mc_alu
    import mc_dp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  alu_mode_e    mode,
    input  logic [5:0]   funct,
    output logic [W-1:0] y,
    output logic         zero
);

    logic [W-1:0] sum, diff, slt;

    // Purpose: shared arithmetic terms.
    always_comb begin
        sum  = opa + opb;
        diff = opa - opb;
        slt  = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
    end

    // Purpose: select the result by mode and, in function mode, by funct.
    always_comb begin
        unique case (mode)
            ALU_ADD: y = sum;
            ALU_SUB: y = diff;
            ALU_OR:  y = opa | opb;
            default: begin
                case (funct)
                    FN_SUB:  y = diff;
                    FN_AND:  y = opa & opb;
                    FN_OR:   y = opa | opb;
                    FN_SLT:  y = slt;
                    default: y = sum;
                endcase
            end
        endcase
        zero = (y == '0);
    end

endmodule

// File: rtl/mc_unified_mem.sv
// Module: mc_unified_mem
// Behavioural word memory shared by instruction and data accesses. Reads
// are combinational (zero wait). One write port is driven by the datapath.
// A load port writes program and data words and takes priority over the
// datapath write. The contents are not reset.
module mc_unified_mem #(
    parameter int AW = 8,
    parameter int W  = 32,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  addr,
    output logic [W-1:0]  rdata,
    input  logic          dp_we,
    input  logic [W-1:0]  dp_wdata,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [W-1:0]  ld_data
);

    logic [W-1:0]  store_q [DEPTH];
    logic [AW-1:0] widx;
    logic [W-1:0]  wdat;
    logic          wen;
    logic [AW-1:0] ridx;
    logic          unused_addr_bits;

    assign unused_addr_bits = ^{addr[W-1:AW+2], addr[1:0]};

    // Purpose: pick the write source, giving the load port priority.
    always_comb begin
        ridx = addr[AW+1:2];
        wen  = ld_en | dp_we;
        widx = ld_en ? ld_addr : ridx;
        wdat = ld_en ? ld_data : dp_wdata;
    end

    // Purpose: single synchronous write into the array.
    always_ff @(posedge clk) begin
        if (wen) store_q[widx] <= wdat;
    end

    // Purpose: zero-wait read.
    always_comb rdata = store_q[ridx];

    // R10
    mem_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wen |=> (store_q[$past(widx)] == $past(wdat)));

endmodule

// File: rtl/mc_shared_datapath.sv
// Module: mc_shared_datapath
// Multicycle datapath with one memory and one ALU. Every control point is a
// port, so an external sequencer performs one register transfer per cycle.
// Holds PC, IR, MDR, A, B and the result latch, each under its own enable.
// Assumes a synchronous active-low reset and a zero-wait memory.
module mc_shared_datapath
    import mc_dp_pkg::*;
#(
    parameter int MEM_AW = 8,
    parameter int NREG   = 32,
    localparam int RIW   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [31:0]       ld_data,
    input  logic              pc_wr,
    input  logic              pc_wr_cond,
    input  logic              pc_src,
    input  logic              ir_wr,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic              addr_sel,
    input  logic              a_wr,
    input  logic              b_wr,
    input  logic              res_wr,
    input  logic              opa_sel,
    input  logic [1:0]        opb_sel,
    input  logic [1:0]        alu_mode,
    input  logic              imm_sext,
    input  logic              dst_sel,
    input  logic              wb_sel,
    input  logic              rf_wr,
    output logic [31:0]       pc_q,
    output logic [31:0]       ir_q,
    output logic [31:0]       mdr_q,
    output logic [31:0]       a_q,
    output logic [31:0]       b_q,
    output logic [31:0]       res_q,
    output logic              alu_zero
);

    word_t          mem_addr, mem_rdata;
    word_t          imm_ext, opa, opb, alu_y;
    word_t          rf_a, rf_b, wb_data, pc_next;
    logic [RIW-1:0] wb_idx;
    logic           pc_load;
    logic           unused_ir_bits;

    assign unused_ir_bits = ^ir_q[31:26];

    // Purpose: memory address select between PC and result latch.
    always_comb mem_addr = addr_sel ? res_q : pc_q;

    mc_unified_mem #(.AW(MEM_AW), .W(XLEN)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (mem_addr),
        .rdata    (mem_rdata),
        .dp_we    (mem_wr),
        .dp_wdata (b_q),
        .ld_en    (ld_en),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data)
    );

    // Purpose: immediate extension and ALU operand selection.
    always_comb begin
        imm_ext = imm_sext ? {{16{ir_q[15]}}, fld_imm(ir_q)}
                           : {16'h0000, fld_imm(ir_q)};
        opa = opa_sel ? a_q : pc_q;
        unique case (opb_sel_e'(opb_sel))
            OPB_FOUR:   opb = 32'd4;
            OPB_REG:    opb = b_q;
            OPB_IMM_SH: opb = {imm_ext[29:0], 2'b00};
            default:    opb = imm_ext;
        endcase
    end

    mc_alu #(.W(XLEN)) u_alu (
        .opa   (opa),
        .opb   (opb),
        .mode  (alu_mode_e'(alu_mode)),
        .funct (fld_fn(ir_q)),
        .y     (alu_y),
        .zero  (alu_zero)
    );

    // Purpose: write-back register and data selection.
    always_comb begin
        wb_idx  = dst_sel ? fld_rd(ir_q) : fld_rt(ir_q);
        wb_data = wb_sel ? mdr_q : res_q;
    end

    mc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra    (fld_rs(ir_q)),
        .rb    (fld_rt(ir_q)),
        .we    (rf_wr),
        .wa    (wb_idx),
        .wd    (wb_data),
        .rda   (rf_a),
        .rdb   (rf_b)
    );

    // Purpose: next PC source and load condition.
    always_comb begin
        pc_next = pc_src ? res_q : alu_y;
        pc_load = pc_wr | (pc_wr_cond & alu_zero);
    end

    // Purpose: program counter.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= '0;
        else if (pc_load) pc_q <= pc_next;
    end

    // Purpose: instruction and memory data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            mdr_q <= '0;
        end else begin
            if (ir_wr)  ir_q  <= mem_rdata;
            if (mem_rd) mdr_q <= mem_rdata;
        end
    end

    // Purpose: operand latches and ALU result latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            res_q <= '0;
        end else begin
            if (a_wr)   a_q   <= rf_a;
            if (b_wr)   b_q   <= rf_b;
            if (res_wr) res_q <= alu_y;
        end
    end

    // R8
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_wr && !pc_wr_cond) |=> $stable(pc_q));

    // R8
    br_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_wr && pc_wr_cond && !alu_zero) |=> $stable(pc_q));

    // R9
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_wr |=> $stable(ir_q));

    // R9
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_wr |=> $stable(res_q));

    // R2
    mdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd |=> $stable(mdr_q));

endmodule

// File: tb/mc_shared_datapath_tb.sv
// Bench: sequences the datapath through complete instructions and compares
// every latch against a software model of the instruction semantics.
module mc_shared_datapath_tb;

    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic ld_en;
    logic [AW-1:0] ld_addr;
    logic [31:0] ld_data;
    logic pc_wr, pc_wr_cond, pc_src, ir_wr, mem_rd, mem_wr, addr_sel;
    logic a_wr, b_wr, res_wr, opa_sel, imm_sext, dst_sel, wb_sel, rf_wr;
    logic [1:0] opb_sel, alu_mode;
    logic [31:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;
    logic alu_zero;

    int n_chk = 0;
    int n_bad = 0;

    // Software model state.
    logic [31:0] m_regs [32];
    logic [31:0] m_mem  [1 << AW];
    logic [31:0] m_pc;

    always #5 clk = ~clk;

    mc_shared_datapath #(.MEM_AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
        .pc_src(pc_src), .ir_wr(ir_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .addr_sel(addr_sel), .a_wr(a_wr), .b_wr(b_wr), .res_wr(res_wr),
        .opa_sel(opa_sel), .opb_sel(opb_sel), .alu_mode(alu_mode),
        .imm_sext(imm_sext), .dst_sel(dst_sel), .wb_sel(wb_sel),
        .rf_wr(rf_wr), .pc_q(pc_q), .ir_q(ir_q), .mdr_q(mdr_q), .a_q(a_q),
        .b_q(b_q), .res_q(res_q), .alu_zero(alu_zero)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic idle();
        ld_en = 0; ld_addr = '0; ld_data = '0;
        pc_wr = 0; pc_wr_cond = 0; pc_src = 0; ir_wr = 0; mem_rd = 0;
        mem_wr = 0; addr_sel = 0; a_wr = 0; b_wr = 0; res_wr = 0;
        opa_sel = 0; opb_sel = 0; alu_mode = 0; imm_sext = 0;
        dst_sel = 0; wb_sel = 0; rf_wr = 0;
    endtask

    // One clock with the current controls, then return to idle.
    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    function automatic logic [31:0] sx(input logic [15:0] i);
        return {{16{i[15]}}, i};
    endfunction

    function automatic logic [31:0] fn_model(input logic [5:0] f,
                                             input logic [31:0] x,
                                             input logic [31:0] y);
        case (f)
            6'h23:   return x - y;
            6'h24:   return x & y;
            6'h25:   return x | y;
            6'h2A:   return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            default: return x + y;
        endcase
    endfunction

    function automatic int widx(input logic [31:0] byte_addr);
        return int'((byte_addr >> 2) & 32'hFF);
    endfunction

    task automatic preload(input int idx, input logic [31:0] w);
        ld_en = 1; ld_addr = AW'(idx); ld_data = w;
        tick();
        m_mem[idx] = w;
    endtask

    // Place the word at the PC, fetch it, then decode. rs and rt are read
    // into A and B, and the branch target goes to the result latch.
    task automatic fetch_decode(input logic [31:0] w);
        preload(widx(m_pc), w);
        addr_sel = 0; ir_wr = 1; opa_sel = 0; opb_sel = 2'd0;
        alu_mode = 2'd0; pc_wr = 1; pc_src = 0;
        tick();
        m_pc = m_pc + 4;
        check("R2 fetch ir", ir_q, w);
        check("R8 pc+4", pc_q, m_pc);
        a_wr = 1; b_wr = 1; res_wr = 1; opa_sel = 0; opb_sel = 2'd2;
        imm_sext = 1; alu_mode = 2'd0;
        tick();
        check("R9 a from rs", a_q, m_regs[w[25:21]]);
        check("R9 b from rt", b_q, m_regs[w[20:16]]);
        check("R3 target", res_q, m_pc + {sx(w[15:0])[29:0], 2'b00});
    endtask

    task automatic post_exec_hold(input logic [31:0] w);
        check("R9 ir holds", ir_q, w);
        check("R8 pc holds", pc_q, m_pc);
    endtask

    task automatic do_rtype(input logic [4:0] rs, input logic [4:0] rt,
                            input logic [4:0] rd, input logic [5:0] f);
        logic [31:0] w, e;
        w = {6'd0, rs, rt, rd, 5'd0, f};
        fetch_decode(w);
        e = fn_model(f, m_regs[rs], m_regs[rt]);
        opa_sel = 1; opb_sel = 2'd1; alu_mode = 2'd2; res_wr = 1;
        tick();
        check("R5 funct result", res_q, e);
        post_exec_hold(w);
        rf_wr = 1; dst_sel = 1; wb_sel = 0;
        tick();
        if (rd != 0) m_regs[rd] = e;
    endtask

    task automatic do_ori(input logic [4:0] rs, input logic [4:0] rt,
                          input logic [15:0] imm);
        logic [31:0] w, e;
        w = {6'h0D, rs, rt, imm};
        fetch_decode(w);
        e = m_regs[rs] | {16'h0, imm};
        opa_sel = 1; opb_sel = 2'd3; imm_sext = 0; alu_mode = 2'd3;
        res_wr = 1;
        tick();
        check("R6 zero-extended or", res_q, e);
        post_exec_hold(w);
        rf_wr = 1; dst_sel = 0; wb_sel = 0;
        tick();
        if (rt != 0) m_regs[rt] = e;
    endtask

    task automatic do_lw(input logic [4:0] rs, input logic [4:0] rt,
                         input logic [15:0] imm);
        logic [31:0] w, ea;
        w = {6'h23, rs, rt, imm};
        fetch_decode(w);
        ea = m_regs[rs] + sx(imm);
        opa_sel = 1; opb_sel = 2'd3; imm_sext = 1; alu_mode = 2'd0;
        res_wr = 1;
        tick();
        check("R6 sign-extended address", res_q, ea);
        addr_sel = 1; mem_rd = 1;
        tick();
        check("R2 mdr from result address", mdr_q, m_mem[widx(ea)]);
        rf_wr = 1; dst_sel = 0; wb_sel = 1;
        tick();
        if (rt != 0) m_regs[rt] = m_mem[widx(ea)];
    endtask

    task automatic do_sw(input logic [4:0] rs, input logic [4:0] rt,
                         input logic [15:0] imm);
        logic [31:0] w, ea;
        w = {6'h2B, rs, rt, imm};
        fetch_decode(w);
        ea = m_regs[rs] + sx(imm);
        opa_sel = 1; opb_sel = 2'd3; imm_sext = 1; alu_mode = 2'd0;
        res_wr = 1;
        tick();
        check("R4 add address", res_q, ea);
        addr_sel = 1; mem_wr = 1;
        tick();
        m_mem[widx(ea)] = m_regs[rt];
        post_exec_hold(w);
    endtask

    task automatic do_beq(input logic [4:0] rs, input logic [4:0] rt,
                          input logic [15:0] imm);
        logic [31:0] w, tgt;
        logic eq;
        w = {6'h04, rs, rt, imm};
        fetch_decode(w);
        tgt = m_pc + {sx(imm)[29:0], 2'b00};
        eq = (m_regs[rs] == m_regs[rt]);
        opa_sel = 1; opb_sel = 2'd1; alu_mode = 2'd1;
        pc_wr_cond = 1; pc_src = 1;
        #1;
        check("R4 subtract zero flag", {31'd0, alu_zero}, {31'd0, eq});
        tick();
        if (eq) m_pc = tgt;
        check("R8 conditional pc", pc_q, m_pc);
        check("R9 ir holds", ir_q, w);
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] corners [8];
        logic [5:0]  fns [7];
        logic [15:0] imms [6];
        logic [15:0] offs [5];
        int k;
        corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                    32'h8000_0000, 32'h1234_5678, 32'hFFFF_FFFE,
                    32'h5555_5555};
        fns  = '{6'h21, 6'h23, 6'h24, 6'h25, 6'h2A, 6'h00, 6'h3F};
        imms = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
        offs = '{16'hFFF8, 16'hFFFC, 16'h0000, 16'h0004, 16'h0008};
        for (int i = 0; i < 32; i++) m_regs[i] = '0;
        for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;
        m_pc = '0;
        idle();
        rst_n = 0;
        // Disturb the controls during reset: reset must win (R1).
        pc_wr = 1; ir_wr = 1; res_wr = 1; a_wr = 1; b_wr = 1; mem_rd = 1;
        repeat (3) @(negedge clk);
        idle();
        for (int i = 0; i < (1 << AW); i++) preload(i, 32'h0);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check("R1 pc reset", pc_q, 32'h0);
        check("R1 ir reset", ir_q, 32'h0);
        check("R1 mdr reset", mdr_q, 32'h0);
        check("R1 a reset", a_q, 32'h0);
        check("R1 b reset", b_q, 32'h0);
        check("R1 res reset", res_q, 32'h0);

        // R1: register file entries read zero after reset.
        do_rtype(5'd7, 5'd31, 5'd0, 6'h21);

        // Corner operands into r1..r8 through loads from word 128 onward.
        for (int i = 0; i < 8; i++) preload(128 + i, corners[i]);
        for (int i = 0; i < 8; i++) do_lw(5'd0, 5'(i + 1), 16'(16'h200 + 4 * i));

        // R5: every funct over every operand pair; some writes aim at r0 (R7).
        k = 0;
        for (int f = 0; f < 7; f++) begin
            for (int i = 1; i <= 8; i++) begin
                for (int j = 1; j <= 8; j++) begin
                    do_rtype(5'(i), 5'(j), (k % 16 == 5) ? 5'd0 : 5'(9 + k % 20),
                             fns[f]);
                    k++;
                end
            end
        end
        // R7: r0 still reads zero after the attempted writes.
        do_rtype(5'd0, 5'd0, 5'd30, 6'h25);
        check("R7 r0 stays zero", m_regs[30], 32'h0);

        // R6: OR with immediates, including bit 15 set.
        for (int i = 0; i <= 8; i++)
            for (int m = 0; m < 6; m++)
                do_ori(5'(i), 5'(10 + m), imms[m]);

        // R10: stores and loads around a base, with negative offsets.
        do_ori(5'd0, 5'd20, 16'h0300);
        for (int i = 0; i < 5; i++) begin
            do_sw(5'd20, 5'(i + 2), offs[i]);
            do_lw(5'd20, 5'd21, offs[i]);
            check("R10 stored b read back", m_regs[21], m_regs[i + 2]);
        end
        do_sw(5'd20, 5'd3, 16'h8000);
        do_lw(5'd20, 5'd22, 16'h8000);

        // R8: branches taken and not taken, forward and backward.
        do_beq(5'd1, 5'd1, 16'h0003);
        do_beq(5'd1, 5'd2, 16'h0003);
        do_beq(5'd3, 5'd3, 16'hFFFE);
        do_beq(5'd4, 5'd5, 16'hFFF0);
        do_beq(5'd0, 5'd0, 16'h0010);
        do_beq(5'd5, 5'd8, 16'h8000);
        do_beq(5'd7, 5'd7, 16'h8000);
        do_rtype(5'd1, 5'd2, 5'd23, 6'h21);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule